// File: doc/BRIEF.md
# Triple-Stage Pixel and Fitness Voter

This block sits behind three redundant image-filter stages that all process the same input picture at the same time. On the pixel side it votes every output pixel as it arrives, so a single misbehaving stage never reaches the downstream stream, and it reports whether the three stages disagreed in that cycle. The pixel vote can be switched off, in which case stage 0's pixel is forwarded unchanged.

On the frame side each stage also delivers a whole-frame fitness score. When the frame is finished a strobe makes the block compare the three scores pairwise against a programmable tolerance. A stage whose score is far from both others, while those two agree, is marked faulty. If no pair agrees, a multiple-fault flag is raised instead. Flags stay set until a clear strobe, and a single-cycle pulse announces the first detection. Because a tolerance is used rather than exact equality, a repaired stage whose score differs slightly is accepted.

Top module: `tmr_pixfit_voter`

## Requirements
- R1: When at least two of the three pixels are equal and voting is enabled, `vote_pix` carries that shared value one clock after the input cycle, and `vote_valid` is `pix_valid` delayed by one clock.
- R2: When voting is enabled and all three pixels differ, `vote_pix` carries stage 0's pixel and both `pix_disagree` and `pix_no_major` are 1 for that output cycle.
- R3: When voting is enabled and the pixels are not all equal but two match, `pix_disagree` is 1 and `pix_no_major` is 0; when all three are equal both are 0. Both flags are 0 in any output cycle where `vote_valid` is 0.
- R4: With `pix_vote_en` at 0 the block forwards stage 0's pixel and holds `pix_disagree` and `pix_no_major` at 0; fitness detection keeps working unchanged.
- R5: Fitness scores are judged only in a cycle with `frame_done` at 1; `stage_fault`, `multi_fault` and `fault_pulse` reflect that judgement one clock later and otherwise hold (apart from clearing).
- R6: Two scores agree when their absolute difference is less than or equal to `fit_tol`. Stage k (bit k of `stage_fault`) is flagged when its score disagrees with both other scores while those two agree.
- R7: When no pair of scores agrees, `multi_fault` is set and no `stage_fault` bit is set by that frame.
- R8: When all three scores agree within the tolerance, including differences exactly equal to `fit_tol`, no flag is set.
- R9: `stage_fault` and `multi_fault` are sticky; a `fault_clear` strobe zeroes them one clock later, but a detection in the same cycle as the clear is still recorded.
- R10: `fault_pulse` is 1 for exactly one clock, in the cycle the flags get a detection, and only if no fault flag was set (after a same-cycle clear) before that detection.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_s0 | input | PIX_W | Stage 0 pixel |
| pix_s1 | input | PIX_W | Stage 1 pixel |
| pix_s2 | input | PIX_W | Stage 2 pixel |
| pix_valid | input | 1 | Shared pixel valid |
| pix_vote_en | input | 1 | 1 = majority vote, 0 = forward stage 0 |
| fit_s0 | input | FIT_W | Stage 0 frame fitness |
| fit_s1 | input | FIT_W | Stage 1 frame fitness |
| fit_s2 | input | FIT_W | Stage 2 frame fitness |
| frame_done | input | 1 | Fitness scores are final this cycle |
| fit_tol | input | FIT_W | Similarity tolerance |
| fault_clear | input | 1 | Clears sticky fault flags |
| vote_pix | output | PIX_W | Voted pixel |
| vote_valid | output | 1 | Voted pixel valid |
| pix_disagree | output | 1 | Stages did not all agree |
| pix_no_major | output | 1 | No two stages agreed |
| stage_fault | output | 3 | Sticky per-stage fault flags |
| multi_fault | output | 1 | Sticky multiple-fault flag |
| fault_pulse | output | 1 | One-cycle first-detection pulse |

## Verification
The assertions watch, on every cycle, that the pixel path delays valid by one clock, that an agreeing pair or the bypass reaches the output, that flags only move on a frame strobe or a clear, that sticky flags never drop without a clear, and that the pulse needs a frame strobe and an empty flag set. Only the bench's scenarios show the tolerance arithmetic: boundary differences equal to the tolerance, which stage is singled out, the multiple-fault choice, and a clear landing together with a new detection.

// File: rtl/tmr_pixfit_pkg.sv
package tmr_pixfit_pkg;
   localparam int unsigned STAGES = 3;

   typedef struct packed {
      logic disagree;
      logic no_major;
   } pix_flag_t;

   function automatic logic [63:0] abs_gap(input logic [63:0] x, input logic [63:0] y);
      return (x >= y) ? (x - y) : (y - x);
   endfunction
endpackage

// File: rtl/pix_majority.sv
module pix_majority
   import tmr_pixfit_pkg::*;
#(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned PIX_PIPE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] in0,
   input  logic [PIX_W-1:0] in1,
   input  logic [PIX_W-1:0] in2,
   input  logic             in_valid,
   input  logic             vote_en,
   output logic [PIX_W-1:0] out_pix,
   output logic             out_valid,
   output pix_flag_t        out_flag
);
   if (PIX_W < 1)   $error("PIX_W must be at least 1");
   if (PIX_PIPE > 1) $error("PIX_PIPE must be 0 or 1");

   logic             eq01, eq02, eq12;
   logic [PIX_W-1:0] pick;
   pix_flag_t        flag_c;

   always_comb begin
      eq01 = (in0 == in1);
      eq02 = (in0 == in2);
      eq12 = (in1 == in2);
      pick = in0;
      flag_c = '0;
      if (vote_en) begin
         if (!eq01 && !eq02 && eq12) pick = in1;
         flag_c.disagree = in_valid && !(eq01 && eq02);
         flag_c.no_major = in_valid && !(eq01 || eq02 || eq12);
      end
   end

   if (PIX_PIPE == 1) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_pix   <= '0;
            out_valid <= 1'b0;
            out_flag  <= '0;
         end else begin
            out_valid <= in_valid;
            out_flag  <= flag_c;
            if (in_valid) out_pix <= pick;
         end
      end

      p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));
      p_pair_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && vote_en && in1 == in2) |=> out_pix == $past(in1));
      p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !vote_en) |=> (out_pix == $past(in0) && !out_flag.disagree && !out_flag.no_major));
      p_nomaj_implies_dis_r2: assert property (@(posedge clk) disable iff (!rst_n)
         out_flag.no_major |-> (out_flag.disagree && out_valid));
   end else begin : g_comb
      assign out_pix   = pick;
      assign out_valid = in_valid;
      assign out_flag  = flag_c;
   end
endmodule

// File: rtl/fit_judge.sv
module fit_judge
   import tmr_pixfit_pkg::*;
#(
   parameter int unsigned FIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FIT_W-1:0] fit0,
   input  logic [FIT_W-1:0] fit1,
   input  logic [FIT_W-1:0] fit2,
   input  logic [FIT_W-1:0] tol,
   input  logic             judge,
   input  logic             clear,
   output logic [STAGES-1:0] stage_flag,
   output logic             multi_flag,
   output logic             first_pulse
);
   if (FIT_W < 2 || FIT_W > 64) $error("FIT_W must lie in 2..64");

   logic [FIT_W-1:0]  fv [STAGES];
   logic [STAGES-1:0] opp_agree;
   logic [STAGES-1:0] lone;
   logic              none_agree;

   assign fv[0] = fit0;
   assign fv[1] = fit1;
   assign fv[2] = fit2;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int unsigned NA = (k + 1) % STAGES;
      localparam int unsigned NB = (k + 2) % STAGES;
      assign opp_agree[k] = abs_gap(64'(fv[NA]), 64'(fv[NB])) <= 64'(tol);
      assign lone[k] = opp_agree[k] && !opp_agree[NA] && !opp_agree[NB];
   end

   assign none_agree = (opp_agree == '0);

   logic [STAGES-1:0] base_stage, new_stage;
   logic              base_multi, new_multi, hit;

   always_comb begin
      base_stage = clear ? '0 : stage_flag;
      base_multi = clear ? 1'b0 : multi_flag;
      new_stage  = judge ? lone : '0;
      new_multi  = judge && none_agree;
      hit        = (new_stage != '0) || new_multi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_flag  <= '0;
         multi_flag  <= 1'b0;
         first_pulse <= 1'b0;
      end else begin
         stage_flag  <= base_stage | new_stage;
         multi_flag  <= base_multi | new_multi;
         first_pulse <= hit && (base_stage == '0) && !base_multi;
      end
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!judge && !clear) |=> ($stable(stage_flag) && $stable(multi_flag)));
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((stage_flag & $past(stage_flag)) == $past(stage_flag)) && (multi_flag || !$past(multi_flag)));
   p_pulse_needs_judge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      first_pulse |-> $past(judge));
   p_pulse_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      first_pulse |-> ($past(clear) || ($past(stage_flag) == '0 && !$past(multi_flag))));
   p_single_lone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lone));
endmodule

// File: rtl/tmr_pixfit_voter.sv
module tmr_pixfit_voter
   import tmr_pixfit_pkg::*;
#(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned FIT_W    = 32,
   parameter int unsigned PIX_PIPE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix_s0,
   input  logic [PIX_W-1:0] pix_s1,
   input  logic [PIX_W-1:0] pix_s2,
   input  logic             pix_valid,
   input  logic             pix_vote_en,
   input  logic [FIT_W-1:0] fit_s0,
   input  logic [FIT_W-1:0] fit_s1,
   input  logic [FIT_W-1:0] fit_s2,
   input  logic             frame_done,
   input  logic [FIT_W-1:0] fit_tol,
   input  logic             fault_clear,
   output logic [PIX_W-1:0] vote_pix,
   output logic             vote_valid,
   output logic             pix_disagree,
   output logic             pix_no_major,
   output logic [2:0]       stage_fault,
   output logic             multi_fault,
   output logic             fault_pulse
);
   pix_flag_t pflag;

   pix_majority #(.PIX_W(PIX_W), .PIX_PIPE(PIX_PIPE)) u_pix (
      .clk(clk), .rst_n(rst_n),
      .in0(pix_s0), .in1(pix_s1), .in2(pix_s2),
      .in_valid(pix_valid), .vote_en(pix_vote_en),
      .out_pix(vote_pix), .out_valid(vote_valid), .out_flag(pflag)
   );

   assign pix_disagree = pflag.disagree;
   assign pix_no_major = pflag.no_major;

   fit_judge #(.FIT_W(FIT_W)) u_fit (
      .clk(clk), .rst_n(rst_n),
      .fit0(fit_s0), .fit1(fit_s1), .fit2(fit_s2),
      .tol(fit_tol), .judge(frame_done), .clear(fault_clear),
      .stage_flag(stage_fault), .multi_flag(multi_fault), .first_pulse(fault_pulse)
   );
endmodule

// File: tb/tmr_pixfit_voter_bench.sv
module tmr_pixfit_voter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  p0 = '0, p1 = '0, p2 = '0;
   logic        pv = 1'b0, ven = 1'b1;
   logic [31:0] f0 = '0, f1 = '0, f2 = '0, tol = '0;
   logic        fdone = 1'b0, fclr = 1'b0;
   logic [7:0]  vpix;
   logic        vval, vdis, vnom, mflt, fpul;
   logic [2:0]  sflt;

   int unsigned n_run = 0, n_fail = 0;
   logic [2:0]  m_stage = '0;
   logic        m_multi = 1'b0;

   always #2 clk = ~clk;

   tmr_pixfit_voter u_tmr_pixfit_voter (
      .clk(clk), .rst_n(rst_n),
      .pix_s0(p0), .pix_s1(p1), .pix_s2(p2), .pix_valid(pv), .pix_vote_en(ven),
      .fit_s0(f0), .fit_s1(f1), .fit_s2(f2), .frame_done(fdone), .fit_tol(tol),
      .fault_clear(fclr),
      .vote_pix(vpix), .vote_valid(vval), .pix_disagree(vdis), .pix_no_major(vnom),
      .stage_fault(sflt), .multi_fault(mflt), .fault_pulse(fpul)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic agree(input logic [31:0] x, input logic [31:0] y, input logic [31:0] t);
      return ((x > y) ? x - y : y - x) <= t;
   endfunction

   // expected pixel outputs for one input cycle
   task automatic pix_cycle(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input logic v, input logic en, input string req);
      logic [7:0] e_pix;
      logic e_dis, e_nom;
      p0 = a; p1 = b; p2 = c; pv = v; ven = en;
      e_pix = a; e_dis = 1'b0; e_nom = 1'b0;
      if (en && v) begin
         if (a != b && a != c && b == c) e_pix = b;
         e_dis = !(a == b && b == c);
         e_nom = (a != b && a != c && b != c);
      end
      step();
      chk({req, " valid"}, 64'(vval), 64'(v));
      if (v) chk({req, " pix"}, 64'(vpix), 64'(e_pix));
      chk({req, " disagree"}, 64'(vdis), 64'(e_dis));
      chk({req, " no_major"}, 64'(vnom), 64'(e_nom));
   endtask

   // one frame judgement, model updates and checks next-cycle flags
   task automatic frame(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic [31:0] t, input logic clr, input string req);
      logic ab, ac, bc, e_pul;
      logic [2:0] det;
      logic dm;
      f0 = a; f1 = b; f2 = c; tol = t; fdone = 1'b1; fclr = clr;
      ab = agree(a, b, t); ac = agree(a, c, t); bc = agree(b, c, t);
      det = {ab && !ac && !bc, ac && !ab && !bc, bc && !ab && !ac};
      dm = !ab && !ac && !bc;
      if (clr) begin m_stage = '0; m_multi = 1'b0; end
      e_pul = (det != '0 || dm) && m_stage == '0 && !m_multi;
      m_stage |= det; m_multi |= dm;
      step();
      fdone = 1'b0; fclr = 1'b0;
      chk({req, " stage_fault"}, 64'(sflt), 64'(m_stage));
      chk({req, " multi_fault"}, 64'(mflt), 64'(m_multi));
      chk({req, " pulse"}, 64'(fpul), 64'(e_pul));
   endtask

   task automatic do_clear();
      fclr = 1'b1;
      m_stage = '0; m_multi = 1'b0;
      step();
      fclr = 1'b0;
      chk("R9 clear stage", 64'(sflt), 64'(0));
      chk("R9 clear multi", 64'(mflt), 64'(0));
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] base;
      process::self().srandom(32'd1234);
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset pix", 64'(vpix), 64'(0));
      chk("R11 reset valid", 64'(vval), 64'(0));
      chk("R11 reset flags", 64'({vdis, vnom, sflt, mflt, fpul}), 64'(0));
      rst_n = 1'b1;
      step();

      // directed pixel corners
      pix_cycle(8'h11, 8'h11, 8'h11, 1, 1, "R3 all equal");
      pix_cycle(8'h20, 8'h20, 8'h99, 1, 1, "R1 pair01");
      pix_cycle(8'h55, 8'h30, 8'h55, 1, 1, "R1 pair02");
      pix_cycle(8'h01, 8'hAA, 8'hAA, 1, 1, "R1 pair12 stage0 outvoted");
      pix_cycle(8'h01, 8'h02, 8'h03, 1, 1, "R2 all differ");
      pix_cycle(8'h01, 8'h02, 8'h03, 0, 1, "R3 invalid no flags");
      pix_cycle(8'h07, 8'hEE, 8'hEE, 1, 0, "R4 bypass");
      pix_cycle(8'h07, 8'h08, 8'h09, 1, 0, "R4 bypass no flags");

      // random pixel mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a, b, c;
         a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
         case ($urandom % 4)
            0: b = a;
            1: c = b;
            2: begin b = a; c = a; end
            default: ;
         endcase
         pix_cycle(a, b, c, ($urandom % 8) != 0, ($urandom % 5) != 0, "R1 random");
      end
      pv = 1'b0;

      // directed fitness corners
      frame(1000, 1010, 990, 10, 0, "R8 within tol boundary");
      step();
      chk("R10 pulse idle", 64'(fpul), 64'(0));
      frame(1000, 1011, 1000, 10, 0, "R8 boundary just outside single");
      frame(5000, 1000, 1005, 10, 0, "R6 stage0 flagged");
      step();
      chk("R10 pulse one cycle", 64'(fpul), 64'(0));
      chk("R5 hold without frame", 64'(sflt), 64'(m_stage));
      frame(100, 2000, 105, 10, 0, "R6 stage1 second detection no pulse");
      do_clear();
      frame(100, 400, 800, 50, 0, "R7 no pair agrees");
      frame(7, 7, 900, 3, 1, "R9 clear with detection");
      do_clear();
      ven = 1'b0;
      frame(300, 300, 10, 5, 0, "R4 fitness works while bypassed");
      ven = 1'b1;
      do_clear();

      // random frames
      for (int i = 0; i < 300; i++) begin
         logic [31:0] t, a, b, c;
         t = 32'($urandom % 1000) + 1;
         base = 32'($urandom % (1 << 30));
         a = base + 32'($urandom % (2 * t + 1));
         b = base + 32'($urandom % (2 * t + 1));
         c = base + 32'($urandom % (2 * t + 1));
         case ($urandom % 4)
            0: a = a + 5 * t;
            1: c = c + 5 * t;
            2: begin b = b + 5 * t; c = c + 11 * t; end
            default: ;
         endcase
         frame(a, b, c, t, ($urandom % 6) == 0, "R6 random frame");
         if (($urandom % 3) == 0) begin
            step();
            chk("R5 random hold", 64'({sflt, mflt, fpul}), 64'({m_stage, m_multi, 1'b0}));
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule